// File: doc/BRIEF.md
# Paged host register and memory port

This block is the parallel host side of a time-slot switch. A host sees a 32-location window and a control register through a 6-bit address bus with an 8-bit data path. The control register picks the internal memory behind the window and which stream page of that memory is shown. Pages are chosen this way because the memories hold 256 entries, which a 6-bit address cannot reach.

Through the window the host can read bytes captured from the input streams. It can also read and write both parts of the connection memory: the 8-bit low part and the 3-bit high part. Writing the low part either sets up a switched connection or loads a message byte. Reading returns the current settings.

The switching engine uses the same memories. It writes captured bytes into the data memory and reads the connection memory for each output channel. A free-running slot counter gives one cycle in every `SLOTS` to the host and leaves every other cycle to the engine. The `host_slot` output tells the engine which cycles it must leave alone. The host holds its select until `hack` rises, and `hack` stays high until the host releases the select.

Top module: `host_window_port`

## Requirements
- R1: The control register is 0 after reset, and a control read returns all 8 bits exactly as last written.
- R2: When `haddr[5]` is 0 the access goes to the control register, whatever the value of `haddr[4:0]`.
- R3: When `haddr[5]` is 1 the access goes to memory, selected by control bits 4:3: 00 or 01 selects the data memory, 10 the connection-memory low part, and 11 the connection-memory high part.
- R4: The memory address is control bits 2:0 (the stream) in address bits 7:5, followed by `haddr[4:0]` (the channel) in bits 4:0.
- R5: Host writes to the connection memory are stored. The engine read port returns `eng_cm_low` and `eng_cm_high` for `eng_cm_addr` one cycle after the address is presented, in a non-host cycle.
- R6: A data-memory read returns the byte the engine wrote at that address. Host writes to the data memory are ignored.
- R7: A read of the connection-memory high part returns its 3 bits in data bits 2:0, and bits 7:3 read as 0.
- R8: `host_slot` is high one cycle in every `SLOTS`. A memory access is performed only on a clock edge where `host_slot` is high, and `hack` rises the cycle after that edge. A control access acknowledges one cycle after the select is sampled.
- R9: While the select is held, `hack` stays high and `hrdata` stays stable. `hack` falls the cycle after the select is released.
- R10: An engine data-memory write presented in a host cycle is dropped.
- R11: While `host_slot` is high, the engine read outputs hold their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel | input | 1 | Host select, held until acknowledge |
| hwr | input | 1 | 1 = write, 0 = read |
| haddr | input | 6 | Host address; bit 5 chooses the window |
| hwdata | input | 8 | Host write data |
| hrdata | output | 8 | Host read data, valid with `hack` |
| hack | output | 1 | Transfer acknowledge |
| host_slot | output | 1 | High in the cycle reserved for the host |
| eng_wr_en | input | 1 | Engine data-memory write enable |
| eng_wr_addr | input | 8 | Engine write address {stream, channel} |
| eng_wr_data | input | 8 | Captured input byte |
| eng_cm_addr | input | 8 | Engine connection-memory read address |
| eng_cm_low | output | 8 | Connection low part, registered |
| eng_cm_high | output | 3 | Connection high part, registered |

## Verification
A control access shows `hack` at the first falling edge after the select is raised, and the bench requires exactly that latency. A memory access shows `hack` one edge after the next host slot. For each memory access the bench records `host_slot` at the falling edge before the acknowledge, requires it to be high, and limits the wait to `SLOTS` cycles. The bench then holds the select for one more cycle to confirm that `hack` and the data hold, and checks that `hack` is low one cycle after release. Engine reads are presented in a chosen kind of cycle and sampled one falling edge later.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
    localparam int DATA_W   = 8;
    localparam int CHAN_W   = 5;
    localparam int STREAM_W = 3;
    localparam int HIGH_W   = 3;
    localparam int MEM_AW   = STREAM_W + CHAN_W;
    localparam int HADDR_W  = CHAN_W + 1;
    localparam int DEPTH    = 1 << MEM_AW;
    localparam int SPARE_W  = DATA_W - 2 - STREAM_W;

    typedef enum logic [1:0] {
        TGT_CTRL,
        TGT_DMEM,
        TGT_CM_LO,
        TGT_CM_HI
    } target_e;

    typedef struct packed {
        logic [SPARE_W-1:0]  spare;
        logic [1:0]          sel;
        logic [STREAM_W-1:0] stream;
    } ctrl_t;

    typedef struct packed {
        logic              we;
        target_e           tgt;
        logic [MEM_AW-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } host_req_t;

    function automatic target_e decode_target(logic [HADDR_W-1:0] a, ctrl_t c);
        if (!a[HADDR_W-1]) return TGT_CTRL;
        case (c.sel)
            2'b10:   return TGT_CM_LO;
            2'b11:   return TGT_CM_HI;
            default: return TGT_DMEM;
        endcase
    endfunction

    function automatic logic [MEM_AW-1:0] page_addr(logic [HADDR_W-1:0] a, ctrl_t c);
        return {c.stream, a[CHAN_W-1:0]};
    endfunction
endpackage

// File: rtl/hwp_slot_timer.sv
module hwp_slot_timer #(
    parameter int SLOTS = 4
) (
    input  logic clk,
    input  logic rst,
    output logic host_slot
);
    localparam int CW = (SLOTS > 2) ? $clog2(SLOTS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign host_slot = (cnt_q == '0);

    p_slot_gap_r8: assert property (@(posedge clk) disable iff (rst)
        host_slot |=> !host_slot);
endmodule

// File: rtl/hwp_access_fsm.sv
module hwp_access_fsm
    import hwp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                hsel,
    input  logic                hwr,
    input  logic [HADDR_W-1:0]  haddr,
    input  logic [DATA_W-1:0]   hwdata,
    input  logic                host_slot,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [DATA_W-1:0]   hrdata,
    output logic                hack,
    output logic                mem_go,
    output host_req_t           mem_req
);
    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACK} state_e;

    state_e  state_q;
    ctrl_t   ctrl_q;
    target_e tgt;
    logic    ctrl_go;

    assign tgt     = decode_target(haddr, ctrl_q);
    assign ctrl_go = (state_q == S_IDLE) && hsel && (tgt == TGT_CTRL);
    assign mem_go  = (state_q != S_ACK) && hsel && (tgt != TGT_CTRL) && host_slot;
    assign mem_req = '{we: hwr, tgt: tgt, addr: page_addr(haddr, ctrl_q), wdata: hwdata};
    assign hack    = (state_q == S_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            ctrl_q  <= '0;
            hrdata  <= '0;
        end else begin
            case (state_q)
                S_IDLE, S_WAIT: begin
                    if (!hsel) begin
                        state_q <= S_IDLE;
                    end else if (ctrl_go) begin
                        if (hwr) ctrl_q <= ctrl_t'(hwdata);
                        else     hrdata <= DATA_W'(ctrl_q);
                        state_q <= S_ACK;
                    end else if (mem_go) begin
                        if (!hwr) hrdata <= mem_rdata;
                        state_q <= S_ACK;
                    end else begin
                        state_q <= S_WAIT;
                    end
                end
                default: if (!hsel) state_q <= S_IDLE;
            endcase
        end
    end

    p_ctrl_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == '0));
    p_ack_after_slot_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(hack) && !$past(ctrl_go)) |-> $past(host_slot));
    p_ack_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (hack && hsel) |=> (hack && $stable(hrdata)));
    p_ack_release_r9: assert property (@(posedge clk) disable iff (rst)
        (hack && !hsel) |=> !hack);
endmodule

// File: rtl/hwp_mem_bank.sv
module hwp_mem_bank
    import hwp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_slot,
    input  logic               host_go,
    input  host_req_t          host_req,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               eng_wr_en,
    input  logic [MEM_AW-1:0]  eng_wr_addr,
    input  logic [DATA_W-1:0]  eng_wr_data,
    input  logic [MEM_AW-1:0]  eng_cm_addr,
    output logic [DATA_W-1:0]  eng_cm_low,
    output logic [HIGH_W-1:0]  eng_cm_high
);
    logic [DATA_W-1:0] dmem  [DEPTH];
    logic [DATA_W-1:0] cm_lo [DEPTH];
    logic [HIGH_W-1:0] cm_hi [DEPTH];

    always_comb begin
        case (host_req.tgt)
            TGT_CM_LO: host_rdata = cm_lo[host_req.addr];
            TGT_CM_HI: host_rdata = {{(DATA_W-HIGH_W){1'b0}}, cm_hi[host_req.addr]};
            default:   host_rdata = dmem[host_req.addr];
        endcase
    end

    always_ff @(posedge clk) begin
        if (eng_wr_en && !host_slot) dmem[eng_wr_addr] <= eng_wr_data;
    end

    always_ff @(posedge clk) begin
        if (host_go && host_req.we && host_req.tgt == TGT_CM_LO)
            cm_lo[host_req.addr] <= host_req.wdata;
    end

    always_ff @(posedge clk) begin
        if (host_go && host_req.we && host_req.tgt == TGT_CM_HI)
            cm_hi[host_req.addr] <= host_req.wdata[HIGH_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_cm_low  <= '0;
            eng_cm_high <= '0;
        end else if (!host_slot) begin
            eng_cm_low  <= cm_lo[eng_cm_addr];
            eng_cm_high <= cm_hi[eng_cm_addr];
        end
    end

    p_host_in_slot_r8: assert property (@(posedge clk) disable iff (rst)
        host_go |-> host_slot);
    p_eng_hold_r11: assert property (@(posedge clk) disable iff (rst)
        host_slot |=> ($stable(eng_cm_low) && $stable(eng_cm_high)));
endmodule

// File: rtl/host_window_port.sv
module host_window_port
    import hwp_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hsel,
    input  logic                hwr,
    input  logic [HADDR_W-1:0]  haddr,
    input  logic [DATA_W-1:0]   hwdata,
    output logic [DATA_W-1:0]   hrdata,
    output logic                hack,
    output logic                host_slot,
    input  logic                eng_wr_en,
    input  logic [MEM_AW-1:0]   eng_wr_addr,
    input  logic [DATA_W-1:0]   eng_wr_data,
    input  logic [MEM_AW-1:0]   eng_cm_addr,
    output logic [DATA_W-1:0]   eng_cm_low,
    output logic [HIGH_W-1:0]   eng_cm_high
);
    logic              slot;
    logic              go;
    host_req_t         req;
    logic [DATA_W-1:0] rd;

    hwp_slot_timer #(.SLOTS(SLOTS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .host_slot (slot)
    );

    hwp_access_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hsel      (hsel),
        .hwr       (hwr),
        .haddr     (haddr),
        .hwdata    (hwdata),
        .host_slot (slot),
        .mem_rdata (rd),
        .hrdata    (hrdata),
        .hack      (hack),
        .mem_go    (go),
        .mem_req   (req)
    );

    hwp_mem_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .host_slot   (slot),
        .host_go     (go),
        .host_req    (req),
        .host_rdata  (rd),
        .eng_wr_en   (eng_wr_en),
        .eng_wr_addr (eng_wr_addr),
        .eng_wr_data (eng_wr_data),
        .eng_cm_addr (eng_cm_addr),
        .eng_cm_low  (eng_cm_low),
        .eng_cm_high (eng_cm_high)
    );

    assign host_slot = slot;
endmodule

// File: tb/host_window_port_test.sv
module host_window_port_test;
    localparam int SLOTS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsel = 1'b0, hwr = 1'b0;
    logic [5:0] haddr = '0;
    logic [7:0] hwdata = '0;
    logic [7:0] hrdata;
    logic       hack, host_slot;
    logic       eng_wr_en = 1'b0;
    logic [7:0] eng_wr_addr = '0, eng_wr_data = '0, eng_cm_addr = '0;
    logic [7:0] eng_cm_low;
    logic [2:0] eng_cm_high;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    host_window_port #(.SLOTS(SLOTS)) uut (
        .clk(clk), .rst(rst), .hsel(hsel), .hwr(hwr), .haddr(haddr),
        .hwdata(hwdata), .hrdata(hrdata), .hack(hack), .host_slot(host_slot),
        .eng_wr_en(eng_wr_en), .eng_wr_addr(eng_wr_addr), .eng_wr_data(eng_wr_data),
        .eng_cm_addr(eng_cm_addr), .eng_cm_low(eng_cm_low), .eng_cm_high(eng_cm_high)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_acc(input logic wr, input logic [5:0] a, input logic [7:0] d,
                            output logic [7:0] rd);
        int   lat;
        logic slot_prev;
        @(negedge clk);
        hsel = 1'b1; hwr = wr; haddr = a; hwdata = d;
        lat = 0;
        slot_prev = host_slot;
        while (lat < 40) begin
            @(negedge clk);
            lat++;
            if (hack) break;
            slot_prev = host_slot;
        end
        check("R8 ack seen", hack, 1);
        if (a[5]) begin
            check("R8 access in host slot", slot_prev, 1);
            check("R8 memory latency bound", lat <= SLOTS, 1);
        end else begin
            check("R8 control latency", lat, 1);
        end
        rd = hrdata;
        @(negedge clk);
        check("R9 ack held", hack, 1);
        check("R9 data held", hrdata, rd);
        hsel = 1'b0;
        @(negedge clk);
        check("R9 ack released", hack, 0);
    endtask

    task automatic eng_write(input logic [7:0] a, input logic [7:0] d, input logic in_slot);
        @(negedge clk);
        while (host_slot !== in_slot) @(negedge clk);
        eng_wr_en = 1'b1; eng_wr_addr = a; eng_wr_data = d;
        @(negedge clk);
        eng_wr_en = 1'b0;
    endtask

    task automatic eng_read(input logic [7:0] a, input logic in_slot);
        @(negedge clk);
        while (host_slot !== in_slot) @(negedge clk);
        eng_cm_addr = a;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] r;
        check("R1 no ack in reset", hack, 0);
        host_acc(1'b0, 6'h00, 8'h00, r);
        check("R1 control resets to zero", r, 8'h00);
    endtask

    task automatic t_ctrl;
        logic [7:0] r;
        host_acc(1'b1, 6'h00, 8'h5A, r);
        host_acc(1'b0, 6'h1F, 8'h00, r);
        check("R2 control via other low bits", r, 8'h5A);
        host_acc(1'b1, 6'h15, 8'hE7, r);
        host_acc(1'b0, 6'h07, 8'h00, r);
        check("R1 all bits read back", r, 8'hE7);
    endtask

    task automatic t_dmem;
        logic [7:0] r;
        eng_write(8'h45, 8'hA7, 1'b0);   // stream 2, channel 5
        eng_write(8'hDF, 8'h3C, 1'b0);   // stream 6, channel 31
        host_acc(1'b1, 6'h00, 8'h02, r);
        host_acc(1'b0, 6'h25, 8'h00, r);
        check("R4 R6 stream 2 channel 5", r, 8'hA7);
        host_acc(1'b1, 6'h00, 8'h0E, r);
        host_acc(1'b0, 6'h3F, 8'h00, r);
        check("R3 select 01 is data memory", r, 8'h3C);
        host_acc(1'b1, 6'h00, 8'h02, r);
        host_acc(1'b1, 6'h25, 8'h11, r);
        host_acc(1'b0, 6'h25, 8'h00, r);
        check("R6 host write ignored", r, 8'hA7);
        eng_write(8'h45, 8'hEE, 1'b1);
        host_acc(1'b0, 6'h25, 8'h00, r);
        check("R10 engine write in host slot dropped", r, 8'hA7);
    endtask

    task automatic t_cmem;
        logic [7:0] r;
        host_acc(1'b1, 6'h00, 8'h13, r);
        host_acc(1'b1, 6'h24, 8'h9B, r);
        host_acc(1'b1, 6'h00, 8'h1B, r);
        host_acc(1'b1, 6'h24, 8'hFF, r);
        host_acc(1'b0, 6'h24, 8'h00, r);
        check("R7 high part zero-extended", r, 8'h07);
        host_acc(1'b1, 6'h00, 8'h13, r);
        host_acc(1'b0, 6'h24, 8'h00, r);
        check("R3 select 10 is low part", r, 8'h9B);
        host_acc(1'b1, 6'h00, 8'h14, r);
        host_acc(1'b1, 6'h24, 8'h42, r);
        host_acc(1'b1, 6'h00, 8'h1C, r);
        host_acc(1'b1, 6'h24, 8'h02, r);
        eng_read(8'h64, 1'b0);
        check("R5 engine low stream 3", eng_cm_low, 8'h9B);
        check("R5 engine high stream 3", eng_cm_high, 3'h7);
        eng_read(8'h84, 1'b0);
        check("R4 engine low stream 4", eng_cm_low, 8'h42);
        check("R4 engine high stream 4", eng_cm_high, 3'h2);
        eng_read(8'h64, 1'b1);
        check("R11 hold during host slot", eng_cm_low, 8'h42);
        @(negedge clk);
        check("R11 update after host slot", eng_cm_low, 8'h9B);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_ctrl;
        t_dmem;
        t_cmem;
        done = 1'b1;
        summary;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            summary;
        end
    end
endmodule